// File: doc/BRIEF.md
# Selectable-Rate Digital Quadrature Mixer

This block sits between the interpolation filters and a pair of DAC channels. Every output clock it takes one signed I sample and one signed Q sample, already at the DAC update rate. It translates them in frequency by one half, one quarter or one eighth of that output rate. The carriers come from a three-bit phase accumulator that steps once per output sample. It addresses an eight-point cosine table, and the sine is read from the same table two points behind.

Two mixing styles are offered. In real mixing, each channel is multiplied by the cosine carrier on its own and the two paths never meet. In complex mixing, the paths form a complex multiplier. A sign input chooses a negative-frequency rotation, which rejects the upper image after an external analog quadrature modulator, or a positive-frequency rotation, which rejects the lower one. When no shift is selected, the samples pass through unchanged.

Top module: `quad_mixer`

## Requirements
- R1: While rst_ni is low, both outputs are 0. After release, the phase accumulator starts at phase 0.
- R2: With shift_sel_i = 2'b00, each output equals its input one clock earlier, and real_mix_i and rot_pos_i have no effect.
- R3: shift_sel_i selects the phase step per output sample: 2'b01 gives fs/2 (step 4), 2'b10 gives fs/4 (step 2) and 2'b11 gives fs/8 (step 1). Phase k gives the carrier cos(2πk/8) and sin(2πk/8).
- R4: In any clock where shift_sel_i differs from its value in the previous clock, the sample is mixed at phase 0. Later samples advance from there.
- R5: With real_mix_i = 1, i_data_o = a·cos and q_data_o = b·cos, where a is the I input and b is the Q input.
- R6: With real_mix_i = 0 and rot_pos_i = 0 (e^-jωt), i_data_o = a·cos + b·sin and q_data_o = b·cos − a·sin.
- R7: With real_mix_i = 0 and rot_pos_i = 1 (e^+jωt), i_data_o = a·cos − b·sin and q_data_o = b·cos + a·sin.
- R8: Carrier values are integers scaled by 32768, with unity exact at 32768 and 0.7071 as 23170. Each output is (sum of products + 16384) arithmetically shifted right by 15, so unity gain reproduces the input exactly.
- R9: Results outside the output range saturate to 2047 or −2048.
- R10: The latency from input to output is exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output-rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| i_data_i | input | 12 | I sample, two's complement |
| q_data_i | input | 12 | Q sample, two's complement |
| shift_sel_i | input | 2 | 00 none, 01 fs/2, 10 fs/4, 11 fs/8 |
| real_mix_i | input | 1 | 1 real mixing, 0 complex mixing |
| rot_pos_i | input | 1 | Complex rotation sign: 0 e^-jωt, 1 e^+jωt |
| i_data_o | output | 12 | Mixed I sample to DAC |
| q_data_o | output | 12 | Mixed Q sample to DAC |

## Verification
A phase accumulator that starts at the wrong point or steps by the wrong amount shows up on the first mixed sample after a mode change. A wrong phase puts a rotated or zeroed value at the ports within one clock. A phase error that appears later misaligns every later sample for the rest of the carrier period. A swapped or missing sine sign looks correct in real mixing and in bypass. It only shows up in complex mixing at odd fs/8 phases and at fs/4 quadrature phases, so those cases are driven with both rotation signs. Rounding and saturation faults show up as an error of one count or as wraparound, on chosen fs/8 values and on full-scale inputs.

// File: rtl/qmix_pkg.sv
package qmix_pkg;
  localparam int PH_W   = 3;
  localparam int COEF_W = 17;
  localparam int FRAC_W = COEF_W - 2;
  localparam int UNITY  = 2 ** FRAC_W;
  localparam int HALF_R2 = 23170;

  typedef enum logic [1:0] {
    SH_NONE = 2'b00,
    SH_FS2  = 2'b01,
    SH_FS4  = 2'b10,
    SH_FS8  = 2'b11
  } shift_sel_e;

  function automatic logic [PH_W-1:0] phase_step(logic [1:0] sel);
    case (shift_sel_e'(sel))
      SH_FS2:  return PH_W'(4);
      SH_FS4:  return PH_W'(2);
      SH_FS8:  return PH_W'(1);
      default: return '0;
    endcase
  endfunction

  function automatic logic signed [COEF_W-1:0] cos_lut(logic [PH_W-1:0] k);
    case (k)
      3'd0:    return COEF_W'(UNITY);
      3'd1:    return COEF_W'(HALF_R2);
      3'd3:    return COEF_W'(-HALF_R2);
      3'd4:    return COEF_W'(-UNITY);
      3'd5:    return COEF_W'(-HALF_R2);
      3'd7:    return COEF_W'(HALF_R2);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/qmix_phase.sv
module qmix_phase
  import qmix_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      shift_sel_i,
  output logic [PH_W-1:0] phase_o
);
  logic [1:0]      sel_q;
  logic [PH_W-1:0] ph_q;
  logic            sel_chg;

  assign sel_chg = (shift_sel_i != sel_q);
  assign phase_o = sel_chg ? '0 : ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 2'b00;
      ph_q  <= '0;
    end else begin
      sel_q <= shift_sel_i;
      ph_q  <= phase_o + phase_step(shift_sel_i);
    end
  end

  p_fs2_grid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_sel_i == SH_FS2) |-> (phase_o[1:0] == 2'b00));
  p_fs4_grid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_sel_i == SH_FS4) |-> (phase_o[0] == 1'b0));
  p_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_sel_i != $past(shift_sel_i)) |-> (phase_o == '0));
endmodule

// File: rtl/qmix_carrier.sv
module qmix_carrier
  import qmix_pkg::*;
(
  input  logic [PH_W-1:0]          phase_i,
  input  logic                     rot_pos_i,
  output logic signed [COEF_W-1:0] cos_o,
  output logic signed [COEF_W-1:0] sin_o
);
  logic signed [COEF_W-1:0] sin_raw;

  assign cos_o   = cos_lut(phase_i);
  // sine lags cosine by a quarter turn = two table points
  assign sin_raw = cos_lut(phase_i - PH_W'(2));
  assign sin_o   = rot_pos_i ? sin_raw : -sin_raw;
endmodule

// File: rtl/qmix_rotator.sv
module qmix_rotator #(
  parameter int DATA_W = 12,
  parameter int COEF_W = 17,
  parameter int FRAC_W = 15
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  input  logic signed [COEF_W-1:0] cos_i,
  input  logic signed [COEF_W-1:0] sin_i,
  input  logic                     cplx_i,
  output logic signed [DATA_W-1:0] re_o,
  output logic signed [DATA_W-1:0] im_o
);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic signed [SUM_W-1:0] RND_HALF = SUM_W'(2 ** (FRAC_W - 1));
  localparam logic signed [SUM_W-1:0] MAX_S    = SUM_W'(2 ** (DATA_W - 1) - 1);
  localparam logic signed [SUM_W-1:0] MIN_S    = -MAX_S - SUM_W'(1);
  localparam logic signed [COEF_W-1:0] UNITY_C = COEF_W'(2 ** FRAC_W);

  logic signed [COEF_W-1:0] s_eff;
  logic signed [DATA_W-1:0] res [2];
  logic signed [DATA_W-1:0] out_q [2];

  assign s_eff = cplx_i ? sin_i : '0;

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic signed [PROD_W-1:0] p_main, p_cross;
    logic signed [SUM_W-1:0]  sum, rnd;
    if (ch == 0) begin : g_re
      assign p_main  = a_i * cos_i;
      assign p_cross = -(b_i * s_eff);
    end else begin : g_im
      assign p_main  = b_i * cos_i;
      assign p_cross = a_i * s_eff;
    end
    assign sum = SUM_W'(p_main) + SUM_W'(p_cross);
    assign rnd = (sum + RND_HALF) >>> FRAC_W;
    always_comb begin
      if (rnd > MAX_S)      res[ch] = MAX_S[DATA_W-1:0];
      else if (rnd < MIN_S) res[ch] = MIN_S[DATA_W-1:0];
      else                  res[ch] = rnd[DATA_W-1:0];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) out_q[ch] <= '0;
      else         out_q[ch] <= res[ch];
    end
  end

  assign re_o = out_q[0];
  assign im_o = out_q[1];

  p_unity_exact_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cos_i == UNITY_C && s_eff == '0) |=> (re_o == $past(a_i) && im_o == $past(b_i)));
  p_real_null_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cplx_i && cos_i == '0) |=> (re_o == '0 && im_o == '0));
endmodule

// File: rtl/quad_mixer.sv
module quad_mixer
  import qmix_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] i_data_i,
  input  logic [DATA_W-1:0] q_data_i,
  input  logic [1:0]        shift_sel_i,
  input  logic              real_mix_i,
  input  logic              rot_pos_i,
  output logic [DATA_W-1:0] i_data_o,
  output logic [DATA_W-1:0] q_data_o
);
  logic [PH_W-1:0]          phase;
  logic signed [COEF_W-1:0] cos_c, sin_c;
  logic signed [DATA_W-1:0] re_s, im_s;

  qmix_phase u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shift_sel_i (shift_sel_i),
    .phase_o     (phase)
  );

  qmix_carrier u_carrier (
    .phase_i   (phase),
    .rot_pos_i (rot_pos_i),
    .cos_o     (cos_c),
    .sin_o     (sin_c)
  );

  qmix_rotator #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .FRAC_W (FRAC_W)
  ) u_rot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    ($signed(i_data_i)),
    .b_i    ($signed(q_data_i)),
    .cos_i  (cos_c),
    .sin_i  (sin_c),
    .cplx_i (!real_mix_i),
    .re_o   (re_s),
    .im_o   (im_s)
  );

  assign i_data_o = re_s;
  assign q_data_o = im_s;

  p_bypass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_sel_i == SH_NONE) |=> (i_data_o == $past(i_data_i) && q_data_o == $past(q_data_i)));
endmodule

// File: tb/tb_quad_mixer.sv
module tb_quad_mixer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] i_data_i = '0, q_data_i = '0;
  logic [1:0]  shift_sel_i = 2'b00;
  logic        real_mix_i = 1'b1, rot_pos_i = 1'b0;
  logic [11:0] i_data_o, q_data_o;

  int n_checks = 0, n_fail = 0;
  int m_prev = 0, m_ph = 0;

  always #2.5 clk_i = ~clk_i;

  quad_mixer dut (.*);

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int coef(int k, bit want_sin);
    real ang = 2.0 * 3.14159265358979 * k / 8.0;
    real v = want_sin ? $sin(ang) : $cos(ang);
    return $rtoi($floor(32768.0 * v + 0.5));
  endfunction

  function automatic int rnd_sat(longint s);
    longint r = (s + 16384) >>> 15;
    if (r > 2047) return 2047;
    if (r < -2048) return -2048;
    return int'(r);
  endfunction

  // drive one sample, compute model, check after the next edge (R10)
  task automatic step(int sel, bit rm, bit pos, int a, int b, string req);
    int c, s, st, ei, eq;
    @(negedge clk_i);
    i_data_i = a[11:0]; q_data_i = b[11:0];
    shift_sel_i = sel[1:0]; real_mix_i = rm; rot_pos_i = pos;
    if (sel != m_prev) m_ph = 0;
    st = (sel == 1) ? 4 : (sel == 2) ? 2 : (sel == 3) ? 1 : 0;
    c = coef(m_ph, 1'b0);
    s = coef(m_ph, 1'b1);
    if (!pos) s = -s;
    if (rm) s = 0;
    ei = rnd_sat(longint'(a) * c - longint'(b) * s);
    eq = rnd_sat(longint'(b) * c + longint'(a) * s);
    m_ph = (m_ph + st) % 8;
    m_prev = sel;
    @(posedge clk_i); #1;
    check({req, " I"}, int'($signed(i_data_o)), ei);
    check({req, " Q"}, int'($signed(q_data_o)), eq);
  endtask

  function automatic int rs();
    return int'($signed(12'($urandom())));
  endfunction

  task automatic t_reset();
    i_data_i = 12'h3A5; q_data_i = 12'hC11; shift_sel_i = 2'b11;
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 reset I", int'($signed(i_data_o)), 0);
    check("R1 reset Q", int'($signed(q_data_o)), 0);
    @(negedge clk_i); shift_sel_i = 2'b00; rst_ni = 1'b1;
    m_prev = 0; m_ph = 0;
  endtask

  task automatic t_bypass();
    for (int n = 0; n < 8; n++) step(0, n[0], n[1], rs(), rs(), "R2 bypass");
    step(0, 1'b0, 1'b1, -2048, 2047, "R2 bypass edge");
  endtask

  task automatic t_latency();
    step(0, 1'b1, 1'b0, 100, -100, "R10 latency");
    @(negedge clk_i);
    i_data_i = 12'd555; q_data_i = 12'd7;
    #1;
    check("R10 hold I", int'($signed(i_data_o)), 100);
    check("R10 hold Q", int'($signed(q_data_o)), -100);
  endtask

  task automatic t_real(int sel);
    for (int n = 0; n < 16; n++) step(sel, 1'b1, n[2], rs(), rs(), "R5 R3 real");
  endtask

  task automatic t_cplx(int sel, bit pos);
    for (int n = 0; n < 16; n++)
      step(sel, 1'b0, pos, rs(), rs(), pos ? "R7 R3 cplx+" : "R6 R3 cplx-");
  endtask

  task automatic t_restart();
    step(3, 1'b1, 1'b0, 50, 60, "R4 pre");
    step(3, 1'b1, 1'b0, 50, 60, "R4 pre");
    step(3, 1'b1, 1'b0, 50, 60, "R4 pre");
    step(2, 1'b1, 1'b0, 321, -77, "R4 restart phase0");
    step(2, 1'b1, 1'b0, 321, -77, "R4 second fs4");
    step(1, 1'b0, 1'b1, 400, 9, "R4 restart fs2");
    step(1, 1'b0, 1'b1, 400, 9, "R4 fs2 half");
  endtask

  task automatic t_round();
    step(0, 1'b1, 1'b0, 0, 0, "R8 prep");
    step(3, 1'b1, 1'b0, 1, -1, "R8 unity");
    step(3, 1'b1, 1'b0, 1, -1, "R8 fs8 one");
    step(3, 1'b1, 1'b0, 3, -3, "R8 fs8 three");
    step(3, 1'b0, 1'b0, 7, 5, "R8 fs8 cplx");
  endtask

  task automatic t_sat();
    step(2, 1'b0, 1'b1, -2048, -2048, "R9 pre");
    step(2, 1'b0, 1'b1, -2048, -2048, "R9 fs4 neg");
    step(0, 1'b1, 1'b0, 0, 0, "R9 prep");
    step(3, 1'b0, 1'b0, 2047, 2047, "R9 fs8 ph0");
    step(3, 1'b0, 1'b0, 2047, -2048, "R9 fs8 ph1");
    step(3, 1'b0, 1'b1, -2048, -2048, "R9 fs8 ph2");
    step(3, 1'b0, 1'b1, -2048, 2047, "R9 fs8 ph3");
  endtask

  initial begin
    #100us;
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_bypass();
    t_latency();
    t_real(1);
    t_real(2);
    t_real(3);
    t_cplx(3, 1'b0);
    t_cplx(3, 1'b1);
    t_cplx(2, 1'b0);
    t_cplx(2, 1'b1);
    t_cplx(1, 1'b1);
    t_restart();
    t_round();
    t_sat();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule